// File: doc/BRIEF.md
# Single-Channel Byte Mover

This block is the data engine of one DMA channel once its descriptor has been decoded. A sequencer supplies a source and a destination address, a byte count for each side, an access style per side (stepping or pinned address), a transfer mode and a descriptor-origin flag. It then pulses `start`. The mover fetches source bytes through a read-request / read-response pair of valid/ready channels into an internal staging buffer. It drains the buffer through a valid/ready write channel and pulses `done` when the job is finished. A running byte total is kept for software to read, and software clears it with a write-ones-to-clear mask.

Three modes exist (`mode` code 0 copy, code 1 fill, code 2 read-only; code 3 acts as copy). In fill mode no source reads are made: the destination byte count sets the job length, and the low bus-width bytes of the `fill_words` pattern are written again and again. In read-only mode source data is fetched and discarded. Pinned-address access, fill mode and read-only mode exist only for register-origin jobs (`reg_origin`=1). For a memory-origin job the mover always copies with stepping addresses on both sides.

Every request and write channel holds valid, address, length and data steady until ready is seen. The mover never withdraws a request. The read-response channel accepts one response per request, and that response carries all requested bytes, little-endian from bit 0. If a clear and an addition to the total fall on the same cycle, the clear is applied first.

Top module: `dma_simple_mover`

## Requirements
- R1: During and straight after reset, `busy`, `done`, `dst_done_evt`, `rd_req_valid`, `rd_rsp_ready` and `wr_valid` are 0, and `total_bytes` is 0.
- R2: In copy mode with both sides stepping, the source is read in chunks of at most BUF_BYTES bytes at incrementing addresses. Each chunk is written to an incrementing destination address with the same bytes (byte i at bits 8i+7..8i). For a register-origin job the length is `src_size`, and `dst_size` has no effect on the writes.
- R3: With source access pinned (`src_step`=0, register origin), every read request is at most BUS_W/8 bytes long and uses the start source address.
- R4: With destination access pinned (`dst_step`=0, register origin), each chunk is split into writes of at most BUS_W/8 bytes, all at the start destination address, each carrying the next unwritten chunk bytes from bit 0.
- R5: In fill mode (`mode`=1, register origin), no read request is issued. The job length is `dst_size`, and each write carries at most BUS_W/8 bytes taken from the low bytes of `fill_words`.
- R6: In read-only mode (`mode`=2, register origin), source reads proceed as in R2/R3, no write is issued, and the total still grows by every chunk.
- R7: For a memory-origin job (`reg_origin`=0), `mode`, `src_step` and `dst_step` are ignored, and the job runs as a stepping copy of `src_size` bytes.
- R8: When `dst_intr` is set, `dst_done_evt` pulses for one cycle after a write that empties the destination remainder. For a register-origin copy or read-only job, the remainder is the unwritten part of the current chunk. Otherwise it is `dst_size` minus the bytes written.
- R9: `total_bytes` grows by the length of every chunk moved and stays unchanged while idle. A cycle with `total_clr_valid` clears the bits set in `total_clr_mask`.
- R10: `done` is high for exactly one cycle, the cycle after the last write handshake (the last read response in read-only mode). For a zero-length job it comes the cycle after `start`. `busy` is high from the cycle after `start` up to and including the `done` cycle.
- R11: A `start` pulse while `busy` is high is ignored, even if the job inputs change.
- R12: While a read request or a write waits for ready, its valid, address, length and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled while idle) |
| reg_origin | input | 1 | 1: register-origin job, 0: memory-origin job |
| mode | input | 2 | 0 copy, 1 fill, 2 read-only |
| src_step | input | 1 | Source access: 1 stepping, 0 pinned |
| dst_step | input | 1 | Destination access: 1 stepping, 0 pinned |
| src_addr | input | ADDR_W | Source start byte address |
| dst_addr | input | ADDR_W | Destination start byte address |
| src_size | input | LEN_W | Source byte count |
| dst_size | input | LEN_W | Destination byte count |
| dst_intr | input | 1 | Enable destination-emptied events |
| fill_words | input | 128 | Fill-mode pattern |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| dst_done_evt | output | 1 | Destination-emptied event pulse |
| total_bytes | output | TOT_W | Running byte total |
| total_clr_valid | input | 1 | Apply clear mask this cycle |
| total_clr_mask | input | TOT_W | Bits of the total to clear |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_req_len | output | $clog2(BUF_BYTES+1) | Read length in bytes |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Mover can take read data |
| rd_rsp_data | input | BUF_BYTES*8 | Read data, byte 0 at bit 0 |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_len | output | $clog2(BUF_BYTES+1) | Write length in bytes |
| wr_data | output | BUF_BYTES*8 | Write data, byte 0 at bit 0 |

## Verification
The assertions assume that the memory side returns exactly one response per accepted read request and raises `rd_rsp_valid` only while a request is outstanding. They also assume that `start` is not raised in reset. The bench's memory model answers a request only after its handshake, with all requested bytes at once. It varies both ready signals on fixed cycle patterns so that holds happen on every channel. Job inputs change mid-run only in the deliberate R11 case, and job lengths always fit in LEN_W.

// File: rtl/mv_pkg.sv
package mv_pkg;
  typedef enum logic [1:0] {
    MV_COPY = 2'd0,
    MV_FILL = 2'd1,
    MV_READ = 2'd2
  } mv_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RRSP,
    ST_FILL,
    ST_WR,
    ST_DONE
  } mv_state_e;
endpackage

// File: rtl/mv_beat_len.sv
module mv_beat_len #(
  parameter int IN_W   = 16,
  parameter int CW     = 5,
  parameter int WIDE   = 16,
  parameter int NARROW = 8
) (
  input  logic [IN_W-1:0] rem,
  input  logic            narrow,
  output logic [CW-1:0]   len
);
  localparam int CAP_W = (IN_W > CW) ? IN_W : CW;

  logic [CAP_W-1:0] r, cap;

  always_comb begin
    r   = CAP_W'(rem);
    cap = narrow ? CAP_W'(NARROW) : CAP_W'(WIDE);
    len = (r < cap) ? CW'(r) : CW'(cap);
  end
endmodule

// File: rtl/mv_stage_buf.sv
module mv_stage_buf #(
  parameter int BYTES = 16,
  parameter int CW    = 5,
  localparam int W    = BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [W-1:0]  load_data,
  input  logic [CW-1:0] off,
  output logic [W-1:0]  data
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       store_q <= '0;
    else if (load_en) store_q <= load_data;
  end

  // unread bytes are presented from bit 0
  assign data = store_q >> {off, 3'b000};
endmodule

// File: rtl/mv_total_acc.sv
module mv_total_acc #(
  parameter int TOT_W = 32,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CW-1:0]    add_len,
  input  logic             clr_en,
  input  logic [TOT_W-1:0] clr_mask,
  output logic [TOT_W-1:0] total
);
  logic [TOT_W-1:0] total_q, base;

  always_comb base = clr_en ? (total_q & ~clr_mask) : total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= base + (add_en ? TOT_W'(add_len) : '0);
  end

  assign total = total_q;
endmodule

// File: rtl/dma_simple_mover.sv
module dma_simple_mover
  import mv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUS_W     = 64,
  parameter int BUF_BYTES = 16,
  parameter int TOT_W     = 32,
  localparam int CW       = $clog2(BUF_BYTES + 1),
  localparam int BUF_W    = BUF_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reg_origin,
  input  logic [1:0]        mode,
  input  logic              src_step,
  input  logic              dst_step,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  src_size,
  input  logic [LEN_W-1:0]  dst_size,
  input  logic              dst_intr,
  input  logic [127:0]      fill_words,
  output logic              busy,
  output logic              done,
  output logic              dst_done_evt,
  output logic [TOT_W-1:0]  total_bytes,
  input  logic              total_clr_valid,
  input  logic [TOT_W-1:0]  total_clr_mask,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [CW-1:0]     rd_req_len,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [BUF_W-1:0]  rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CW-1:0]     wr_len,
  output logic [BUF_W-1:0]  wr_data
);
  localparam int BUS_BYTES = BUS_W / 8;

  mv_state_e         st_q;
  mv_mode_e          mode_q, mode_in;
  logic              sfix_q, dfix_q, regm_q, intr_q, evt_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  rem_q, drem_q, len_in;
  logic [CW-1:0]     chunk_q, left_q, off_q;
  logic [CW-1:0]     chunk_len, wlen;
  logic [BUF_W-1:0]  buf_out, load_data;
  logic              rq_hs, rs_hs, w_hs, last_wr, job_end, ev_chunk, add_en, load_en;

  // effective job settings: memory-origin jobs are always stepping copies
  always_comb begin
    mode_in = MV_COPY;
    if (reg_origin) begin
      case (mode)
        2'd1:    mode_in = MV_FILL;
        2'd2:    mode_in = MV_READ;
        default: mode_in = MV_COPY;
      endcase
    end
    len_in = (mode_in == MV_FILL) ? dst_size : src_size;
  end

  mv_beat_len #(.IN_W(LEN_W), .CW(CW), .WIDE(BUF_BYTES), .NARROW(BUS_BYTES)) u_chunk_len (
    .rem(rem_q), .narrow(sfix_q || (mode_q == MV_FILL)), .len(chunk_len));

  mv_beat_len #(.IN_W(CW), .CW(CW), .WIDE(BUF_BYTES), .NARROW(BUS_BYTES)) u_write_len (
    .rem(left_q), .narrow(dfix_q), .len(wlen));

  assign rq_hs    = rd_req_valid && rd_req_ready;
  assign rs_hs    = rd_rsp_valid && rd_rsp_ready;
  assign w_hs     = wr_valid && wr_ready;
  assign last_wr  = w_hs && (left_q == wlen);
  assign job_end  = (rem_q == LEN_W'(chunk_q));
  assign ev_chunk = regm_q && (mode_q != MV_FILL);
  assign add_en   = (rs_hs && (mode_q == MV_READ)) || last_wr;
  assign load_en  = (st_q == ST_FILL) || rs_hs;
  assign load_data = (st_q == ST_FILL) ? BUF_W'(fill_words) : rd_rsp_data;

  mv_stage_buf #(.BYTES(BUF_BYTES), .CW(CW)) u_stage (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
    .off(off_q), .data(buf_out));

  mv_total_acc #(.TOT_W(TOT_W), .CW(CW)) u_total (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_len(chunk_q),
    .clr_en(total_clr_valid), .clr_mask(total_clr_mask), .total(total_bytes));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= MV_COPY;
      sfix_q  <= 1'b0;
      dfix_q  <= 1'b0;
      regm_q  <= 1'b0;
      intr_q  <= 1'b0;
      evt_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      drem_q  <= '0;
      chunk_q <= '0;
      left_q  <= '0;
      off_q   <= '0;
    end else begin
      evt_q <= w_hs && intr_q &&
               (ev_chunk ? (left_q == wlen) : (drem_q == LEN_W'(wlen)));
      case (st_q)
        ST_IDLE: if (start) begin
          mode_q <= mode_in;
          sfix_q <= reg_origin && !src_step;
          dfix_q <= reg_origin && !dst_step;
          regm_q <= reg_origin;
          intr_q <= dst_intr;
          src_q  <= src_addr;
          dst_q  <= dst_addr;
          rem_q  <= len_in;
          drem_q <= dst_size;
          if (len_in == '0)            st_q <= ST_DONE;
          else if (mode_in == MV_FILL) st_q <= ST_FILL;
          else                         st_q <= ST_RREQ;
        end
        ST_FILL: begin
          chunk_q <= chunk_len;
          left_q  <= chunk_len;
          off_q   <= '0;
          st_q    <= ST_WR;
        end
        ST_RREQ: if (rq_hs) begin
          chunk_q <= chunk_len;
          st_q    <= ST_RRSP;
        end
        ST_RRSP: if (rs_hs) begin
          if (!sfix_q) src_q <= src_q + ADDR_W'(chunk_q);
          left_q <= chunk_q;
          off_q  <= '0;
          if (mode_q == MV_READ) begin
            rem_q <= rem_q - LEN_W'(chunk_q);
            st_q  <= job_end ? ST_DONE : ST_RREQ;
          end else begin
            st_q <= ST_WR;
          end
        end
        ST_WR: if (w_hs) begin
          if (!dfix_q) dst_q <= dst_q + ADDR_W'(wlen);
          left_q <= left_q - wlen;
          off_q  <= off_q + wlen;
          drem_q <= (drem_q > LEN_W'(wlen)) ? drem_q - LEN_W'(wlen) : '0;
          if (last_wr) begin
            rem_q <= rem_q - LEN_W'(chunk_q);
            if (job_end)                 st_q <= ST_DONE;
            else if (mode_q == MV_FILL)  st_q <= ST_FILL;
            else                         st_q <= ST_RREQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign done         = (st_q == ST_DONE);
  assign dst_done_evt = evt_q;
  assign rd_req_valid = (st_q == ST_RREQ);
  assign rd_req_addr  = src_q;
  assign rd_req_len   = chunk_len;
  assign rd_rsp_ready = (st_q == ST_RRSP);
  assign wr_valid     = (st_q == ST_WR);
  assign wr_addr      = dst_q;
  assign wr_len       = wlen;
  assign wr_data      = buf_out;
endmodule

// File: rtl/mv_mover_checks.sv
module mv_mover_checks #(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 16,
  parameter int TOT_W     = 32,
  localparam int CW       = $clog2(BUF_BYTES + 1),
  localparam int BUF_W    = BUF_BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic [CW-1:0]     rd_req_len,
  input logic              rd_rsp_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CW-1:0]     wr_len,
  input logic [BUF_W-1:0]  wr_data,
  input logic [TOT_W-1:0]  total_bytes,
  input logic              total_clr_valid
);
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(wr_data));

  p_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_len != '0) && (int'(rd_req_len) <= BUF_BYTES));

  p_wr_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_len != '0) && (int'(wr_len) <= BUF_BYTES));

  p_one_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, rd_rsp_ready, wr_valid, done}));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_total_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !total_clr_valid |=> $stable(total_bytes));
endmodule

bind dma_simple_mover mv_mover_checks #(
  .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .TOT_W(TOT_W)
) i_mover_checks (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
  .rd_rsp_ready(rd_rsp_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
  .total_bytes(total_bytes), .total_clr_valid(total_clr_valid));

// File: tb/test_dma_simple_mover.sv
`timescale 1ns/100ps
module test_dma_simple_mover;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, reg_origin = 1'b1, src_step = 1'b1, dst_step = 1'b1, dst_intr = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [31:0]  src_addr = '0, dst_addr = '0;
  logic [15:0]  src_size = '0, dst_size = '0;
  logic [127:0] fill_words = '0;
  logic         busy, done, dst_done_evt;
  logic [31:0]  total_bytes;
  logic         total_clr_valid = 1'b0;
  logic [31:0]  total_clr_mask = '0;
  logic         rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, rd_rsp_ready;
  logic [31:0]  rd_req_addr, wr_addr;
  logic [4:0]   rd_req_len, wr_len;
  logic [127:0] rd_rsp_data = '0, wr_data;
  logic         wr_valid, wr_ready = 1'b0;

  always #2.5 clk = ~clk;

  dma_simple_mover i_dma_simple_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_origin(reg_origin), .mode(mode),
    .src_step(src_step), .dst_step(dst_step), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_size(src_size), .dst_size(dst_size), .dst_intr(dst_intr), .fill_words(fill_words),
    .busy(busy), .done(done), .dst_done_evt(dst_done_evt), .total_bytes(total_bytes),
    .total_clr_valid(total_clr_valid), .total_clr_mask(total_clr_mask),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_len(rd_req_len), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_data(wr_data));

  int vec = 0, errs = 0;
  int cyc = 0, ev_cnt = 0, done_cnt = 0, done_cyc = 0, last_x = 0, start_cyc = 0;
  logic [31:0]  tot_model = '0;
  logic [31:0]  rq_a[$];
  int           rq_l[$];
  logic [31:0]  wq_a[$];
  int           wq_l[$];
  logic [127:0] wq_d[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] m;
    m = a * 7 + 3;
    return m[7:0] ^ a[15:8];
  endfunction

  // scoreboard driver side: expected transactions from the requirements
  task automatic predict(input bit regm, input logic [1:0] md, input bit sb, input bit db,
                         input logic [31:0] sa, input logic [31:0] da, input int ssz,
                         input int dsz, input bit intr, input logic [127:0] pat,
                         output int nev, output int nx);
    bit wo, ro, sfx, dfx;
    int rem, c, left, off, w, drem, evr;
    logic [31:0] sp, dp;
    logic [127:0] b;
    wo = regm && md == 2'd1;  ro = regm && md == 2'd2;   // R7: memory origin forces copy
    sfx = regm && !sb;        dfx = regm && !db;
    rem = wo ? dsz : ssz;     sp = sa; dp = da; drem = dsz; nev = 0; nx = 0;
    while (rem > 0) begin
      c = (sfx || wo) ? 8 : 16;
      if (rem < c) c = rem;
      if (wo) b = pat;
      else begin
        rq_a.push_back(sp); rq_l.push_back(c); nx++;
        b = '0;
        for (int j = 0; j < c; j++) b[j*8 +: 8] = mem_byte(sp + 32'(j));
        if (!sfx) sp += 32'(c);
      end
      if (!ro) begin
        left = c; off = 0;
        while (left > 0) begin
          w = (dfx && left > 8) ? 8 : left;
          wq_a.push_back(dp); wq_l.push_back(w); wq_d.push_back(b >> (off * 8)); nx++;
          evr = (regm && !wo) ? left : drem;
          if (intr && evr == w) nev++;
          drem = (drem > w) ? drem - w : 0;
          if (!dfx) dp += 32'(w);
          left -= w; off += w;
        end
      end
      tot_model += 32'(c);
      rem -= c;
    end
  endtask

  // memory model and monitor: all sampling and ready changes at negedge
  initial begin
    bit pend, rsp_hs;
    logic [31:0] paddr;
    int plen;
    logic [127:0] mask, d;
    pend = 0; rsp_hs = 0; paddr = '0; plen = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (rsp_hs) begin rd_rsp_valid = 1'b0; rsp_hs = 0; end
      if (pend && !rd_rsp_valid) begin
        d = '0;
        for (int j = 0; j < plen; j++) d[j*8 +: 8] = mem_byte(paddr + 32'(j));
        rd_rsp_data = d; rd_rsp_valid = 1'b1; pend = 0;
      end
      rd_req_ready = (cyc % 4) != 2;
      if (rd_req_valid && rd_req_ready) begin
        if (rq_a.size() == 0) chk(0, "R5 R6", "unexpected read request", rd_req_addr, 0);
        else begin
          chk(rd_req_addr == rq_a[0], "R2 R3", "read address", rd_req_addr, rq_a[0]);
          chk(int'(rd_req_len) == rq_l[0], "R2 R3", "read length", rd_req_len, rq_l[0]);
          void'(rq_a.pop_front()); void'(rq_l.pop_front());
        end
        paddr = rd_req_addr; plen = rd_req_len; pend = 1;
      end
      rsp_hs = rd_rsp_valid && rd_rsp_ready;
      if (rsp_hs) last_x = cyc;
      wr_ready = (cyc % 3) != 1;
      if (wr_valid && wr_ready) begin
        last_x = cyc;
        if (wq_a.size() == 0) chk(0, "R6", "unexpected write", wr_addr, 0);
        else begin
          mask = (128'd1 << (wq_l[0] * 8)) - 128'd1;
          chk(wr_addr == wq_a[0], "R2 R4 R5", "write address", wr_addr, wq_a[0]);
          chk(int'(wr_len) == wq_l[0], "R4 R5", "write length", wr_len, wq_l[0]);
          chk((wr_data & mask) == (wq_d[0] & mask), "R2 R5", "write data",
              wr_data & mask, wq_d[0] & mask);
          void'(wq_a.pop_front()); void'(wq_l.pop_front()); void'(wq_d.pop_front());
        end
      end
      if (start && !busy) start_cyc = cyc;
      if (dst_done_evt) ev_cnt++;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  task automatic run(input string tag, input bit regm, input logic [1:0] md, input bit sb,
                     input bit db, input logic [31:0] sa, input logic [31:0] da,
                     input int ssz, input int dsz, input bit intr, input bit poke);
    int nev, nx, ev0, d0, t;
    @(posedge clk); #1;
    reg_origin = regm; mode = md; src_step = sb; dst_step = db; src_addr = sa; dst_addr = da;
    src_size = 16'(ssz); dst_size = 16'(dsz); dst_intr = intr; start = 1'b1;
    ev0 = ev_cnt; d0 = done_cnt;
    predict(regm, md, sb, db, sa, da, ssz, dsz, intr, fill_words, nev, nx);
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      // R11: a second start with other settings while busy must change nothing
      repeat (3) @(posedge clk);
      #1;
      chk(busy, "R11", "busy before second start", busy, 1);
      src_addr = ~sa; dst_addr = ~da; src_size = 16'd5; mode = 2'd2; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 3000) begin @(posedge clk); t++; end
    @(negedge clk);
    chk(done_cnt == d0 + 1, tag, "single done pulse R10", done_cnt - d0, 1);
    chk(rq_a.size() == 0, tag, "reads left over", rq_a.size(), 0);
    chk(wq_a.size() == 0, tag, "writes left over", wq_a.size(), 0);
    chk(ev_cnt - ev0 == nev, tag, "destination events R8", ev_cnt - ev0, nev);
    chk(total_bytes == tot_model, tag, "running total R9", total_bytes, tot_model);
    chk(done_cyc == ((nx == 0) ? start_cyc : last_x) + 1, tag, "done timing R10",
        done_cyc, ((nx == 0) ? start_cyc : last_x) + 1);
    chk(!busy, tag, "idle after done R10", busy, 0);
    rq_a.delete(); rq_l.delete(); wq_a.delete(); wq_l.delete(); wq_d.delete();
  endtask

  task automatic clear(input logic [31:0] m);
    @(posedge clk); #1;
    total_clr_valid = 1'b1; total_clr_mask = m;
    @(posedge clk); #1;
    total_clr_valid = 1'b0;
    tot_model &= ~m;
    @(negedge clk);
    chk(total_bytes == tot_model, "R9", "total after clear", total_bytes, tot_model);
  endtask

  initial begin
    fill_words = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, done, dst_done_evt, rd_req_valid, rd_rsp_ready, wr_valid} == 6'b0, "R1",
        "outputs in reset", {busy, done, dst_done_evt, rd_req_valid, rd_rsp_ready, wr_valid}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(total_bytes == 0 && !busy && !wr_valid && !rd_req_valid, "R1", "state after reset",
        {total_bytes, busy}, 0);
    run("R2",  1, 2'd0, 1, 1, 32'h1000, 32'h8000, 37, 5, 1, 0);   // chunks 16,16,5
    run("R3",  1, 2'd0, 0, 1, 32'h2003, 32'h9000, 20, 0, 1, 0);   // pinned source
    run("R4",  1, 2'd0, 1, 0, 32'h3000, 32'ha004, 20, 0, 1, 0);   // pinned destination
    run("R5",  1, 2'd1, 1, 1, 32'h4000, 32'hb000, 3, 19, 1, 0);   // fill 8,8,3
    run("R5",  1, 2'd1, 1, 0, 32'h4000, 32'hb100, 0, 12, 0, 0);   // fill, pinned
    run("R6",  1, 2'd2, 1, 1, 32'h5000, 32'hc000, 30, 30, 1, 0);  // read-only
    run("R7",  0, 2'd1, 0, 0, 32'h6000, 32'hd000, 24, 24, 1, 0);  // memory origin
    run("R10", 1, 2'd0, 1, 1, 32'h7000, 32'he000, 0, 9, 1, 0);    // zero length
    run("R11", 1, 2'd0, 1, 1, 32'h7100, 32'he100, 40, 0, 0, 1);
    clear(32'h0000_00f0);
    clear(32'hffff_ffff);
    run("R9",  1, 2'd0, 0, 0, 32'h7200, 32'he200, 11, 0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule